// File: doc/BRIEF.md
# Paired Quad-Lane Flash Command Sequencer

This block runs commands on two identical serial flash devices that work side by side. The devices share one serial clock and one active-low chip select. Each device has its own 4-bit data bus. Internal logic issues a request with an opcode, a logical byte address, a direction, an even byte count, a dummy-clock count and a "poll until ready" flag. The sequencer sends the opcode and the halved address to both devices at once. It then splits the logical byte stream so that even bytes go to device 0 and odd bytes go to device 1. Reads are merged back into one stream in the same order.

When polling is requested, the sequencer runs a status-read frame after the command, in a new chip-select frame. It repeats that frame until neither device reports busy, so completion follows the slower device. A page program must start on a 512-byte logical boundary, and any transfer must have an even byte count. A request that breaks either rule is refused with an error pulse, and no frame is started. Write bytes enter through a valid/ready stream and read bytes leave through another. The serial clock is stopped (held low) while the streams are being served.

The controller FSM has these states: IDLE, OPC (opcode), ADDR, DUMMY, WFETCH (collect a byte pair), WSHIFT (send the pair), RSHIFT (receive a pair), RPUSH (hand the pair out), END (command frame closed), POPC (status opcode), PREAD (status byte) and PEND (poll frame closed). The transitions are as follows:
- IDLE goes to OPC when a request is accepted.
- OPC goes to ADDR, DUMMY or the data phase, depending on address, dummy count and length.
- ADDR goes to DUMMY or the data phase.
- DUMMY goes to the data phase.
- WFETCH goes to WSHIFT after two bytes. WSHIFT returns to WFETCH, or goes to END on the last pair.
- RSHIFT goes to RPUSH. RPUSH returns to RSHIFT, or goes to END on the last pair.
- END goes to POPC when polling is requested, else to IDLE.
- POPC goes to PREAD, and PREAD goes to PEND.
- PEND goes back to POPC while either device is busy, else to IDLE.

Top module: `dual_qflash_seq`

## Requirements
- R1: On a write, logical byte i goes to device 0 when i is even and to device 1 when i is odd. Device 0 uses q_out[3:0] and device 1 uses q_out[7:4]. Each byte is sent as two nibbles, high nibble first, starting at the 9th clock of a frame with an address and no dummy clocks.
- R2: On a read, rd_data delivers device 0's byte k, then device 1's byte k, for k = 0, 1, 2 and so on. rd_data stays stable while rd_valid is high and rd_ready is low.
- R3: The opcode (2 clocks) and the address (6 clocks, most significant nibble first) are driven identically on both 4-bit buses. The address is the logical address shifted right by one, so 0x20000 appears as 0x010000.
- R4: With polling requested, each poll is its own chip-select frame. A poll frame is opcode 0x05 followed by one status byte read from each device. Polling repeats while bit 0 of either status byte is 1, and all other status bits are ignored.
- R5: done pulses for one cycle only after a poll frame in which both status bytes show bit 0 clear. If device 0 stays busy for a polls and device 1 for b polls, exactly max(a,b)+1 poll frames are run.
- R6: A request with opcode 0x02 whose address is not a multiple of 512 raises err and starts no frame.
- R7: A request with an odd byte count raises err and starts no frame.
- R8: sclk idles low and toggles every cfg_div+1 clock cycles, so its rising edges are 2*(cfg_div+1) cycles apart.
- R9: cs_n goes low at least one clock before the first rising edge of sclk. cs_n goes high only while sclk is low.
- R10: During the dummy clocks (their count is taken from the request) and during read data clocks, q_oe is 0 on both devices.
- R11: A request without an address produces a frame of exactly 2 serial clocks when its byte count is 0.
- R12: After reset, cs_n is 1, sclk is 0, q_oe is 0, and busy, done, err, wr_ready and rd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half-period of sclk minus one, in clocks |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | ADDR_W | Logical byte address |
| req_has_addr | input | 1 | Send an address phase |
| req_write | input | 1 | Data direction, 1 = write |
| req_len | input | LEN_W | Logical byte count, must be even |
| req_dummy | input | DUMMY_W | Dummy clocks between address and data |
| req_poll | input | 1 | Poll status after the command |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| sclk | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared chip select, active low |
| q_out | output | 8 | Data out, [3:0] device 0, [7:4] device 1 |
| q_oe | output | 2 | Output enable per device |
| q_in | input | 8 | Data in, [3:0] device 0, [7:4] device 1 |

## Verification
The bench covers several cases:
- A read with dummy clocks at the shortest divider. This separates a correct dummy count and merge order from an off-by-one or swapped lane.
- A page program with distinct byte values. This shows whether even and odd bytes reach the right bus with the high nibble first.
- Erase-and-poll runs where device 0 is slower in one case and device 1 is slower in the other. These catch a sequencer that stops on the first ready device or that checks only one device.
- Misaligned programs and odd counts, which must be refused.
- A bare opcode, and a read at a wider divider, which fix the frame length and clock spacing.

// File: rtl/dqf_pkg.sv
package dqf_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DUMMY,
        S_WFETCH,
        S_WSHIFT,
        S_RSHIFT,
        S_RPUSH,
        S_END,
        S_POPC,
        S_PREAD,
        S_PEND
    } dqf_state_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/dqf_clkgen.sv
module dqf_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt >= div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt >= div);

    // R8: a tick is never followed directly by another one unless the divider is zero
    a_r8_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/dqf_lane.sv
module dqf_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       rx_step,
    input  logic       tx_step,
    input  logic [3:0] nib_in,
    output logic [3:0] nib_out,
    output logic [7:0] byte_q
);

    logic [7:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r <= '0;
        end else if (load) begin
            r <= load_byte;
        end else if (rx_step) begin
            r <= {r[3:0], nib_in};
        end else if (tx_step) begin
            r <= {r[3:0], 4'h0};
        end
    end

    assign nib_out = r[7:4];
    assign byte_q  = r;

endmodule

// File: rtl/dual_qflash_seq.sv
module dual_qflash_seq
    import dqf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 25,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned DUMMY_W    = 4,
    parameter logic [7:0]  PROG_OP    = 8'h02,
    parameter logic [7:0]  STATUS_OP  = 8'h05,
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned BUSY_BIT   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               req_valid,
    input  logic [7:0]         req_opcode,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_has_addr,
    input  logic               req_write,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic               req_poll,
    output logic               busy,
    output logic               done,
    output logic               err,
    input  logic [7:0]         wr_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic               sclk,
    output logic               cs_n,
    output logic [7:0]         q_out,
    output logic [1:0]         q_oe,
    input  logic [7:0]         q_in
);

    localparam int unsigned ADDR_CLKS = (ADDR_W - 1 + 3) / 4;
    localparam int unsigned WIRE_W    = ADDR_CLKS * 4;
    localparam int unsigned SH_W      = 8 + WIRE_W;
    localparam int unsigned PG_LSB    = $clog2(PAGE_BYTES);
    localparam int unsigned CNT_W     = $clog2(ADDR_CLKS + (1 << DUMMY_W) + 2);
    localparam int unsigned PAIR_W    = LEN_W - 1;

    dqf_state_e          state, state_nx;
    logic                sclk_q;
    logic [CNT_W-1:0]    ncnt;
    logic [SH_W-1:0]     sh;
    logic [PAIR_W-1:0]   pairs;
    logic [DUMMY_W-1:0]  dummy_q;
    logic                has_addr_q, write_q, poll_q, half;

    logic                shifting, tick, rise, fall, last;
    logic                bad, busy_any;
    logic [LANES-1:0]       lane_load;
    logic [LANES-1:0][3:0]  lane_nib;
    logic [LANES-1:0][7:0]  lane_byte;
    logic                rx_step, tx_step;
    dqf_state_e          data_st, post_addr_st, post_opc_st;

    // ---------------- serial clock tick source ----------------
    assign shifting = (state == S_OPC) || (state == S_ADDR) || (state == S_DUMMY) ||
                      (state == S_WSHIFT) || (state == S_RSHIFT) ||
                      (state == S_POPC) || (state == S_PREAD);

    dqf_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (shifting),
        .div  (cfg_div),
        .tick (tick)
    );

    assign rise = tick && !sclk_q;
    assign fall = tick && sclk_q;
    assign last = fall && (ncnt == CNT_W'(1));

    // ---------------- per-device byte lanes ----------------
    assign rx_step = rise && ((state == S_RSHIFT) || (state == S_PREAD));
    assign tx_step = fall && (state == S_WSHIFT);
    assign lane_load[0] = (state == S_WFETCH) && wr_valid && !half;
    assign lane_load[1] = (state == S_WFETCH) && wr_valid && half;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dqf_lane i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (lane_load[g]),
            .load_byte(wr_data),
            .rx_step  (rx_step),
            .tx_step  (tx_step),
            .nib_in   (q_in[g*4 +: 4]),
            .nib_out  (lane_nib[g]),
            .byte_q   (lane_byte[g])
        );
    end

    assign busy_any = lane_byte[0][BUSY_BIT] | lane_byte[1][BUSY_BIT];

    // ---------------- request screening ----------------
    assign bad = req_len[0] ||
                 ((req_opcode == PROG_OP) && (req_addr[PG_LSB-1:0] != '0));

    // ---------------- next-state logic ----------------
    assign data_st      = (pairs == '0) ? S_END : (write_q ? S_WFETCH : S_RSHIFT);
    assign post_addr_st = (dummy_q != '0) ? S_DUMMY : data_st;
    assign post_opc_st  = has_addr_q ? S_ADDR : post_addr_st;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid && !bad) state_nx = S_OPC;
            S_OPC:    if (last) state_nx = post_opc_st;
            S_ADDR:   if (last) state_nx = post_addr_st;
            S_DUMMY:  if (last) state_nx = data_st;
            S_WFETCH: if (wr_valid && half) state_nx = S_WSHIFT;
            S_WSHIFT: if (last) state_nx = (pairs == PAIR_W'(1)) ? S_END : S_WFETCH;
            S_RSHIFT: if (last) state_nx = S_RPUSH;
            S_RPUSH:  if (rd_ready && half)
                          state_nx = (pairs == PAIR_W'(1)) ? S_END : S_RSHIFT;
            S_END:    state_nx = poll_q ? S_POPC : S_IDLE;
            S_POPC:   if (last) state_nx = S_PREAD;
            S_PREAD:  if (last) state_nx = S_PEND;
            S_PEND:   state_nx = busy_any ? S_POPC : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            ncnt       <= '0;
            sh         <= '0;
            pairs      <= '0;
            dummy_q    <= '0;
            has_addr_q <= 1'b0;
            write_q    <= 1'b0;
            poll_q     <= 1'b0;
            half       <= 1'b0;
        end else begin
            if (tick) sclk_q <= !sclk_q;

            if (state_nx != state) begin
                case (state_nx)
                    S_ADDR:  ncnt <= CNT_W'(ADDR_CLKS);
                    S_DUMMY: ncnt <= CNT_W'(dummy_q);
                    default: ncnt <= CNT_W'(2);
                endcase
            end else if (fall) begin
                ncnt <= ncnt - 1'b1;
            end

            if (state == S_IDLE && req_valid && !bad) begin
                sh         <= {req_opcode, WIRE_W'(req_addr >> 1)};
                pairs      <= req_len[LEN_W-1:1];
                dummy_q    <= req_dummy;
                has_addr_q <= req_has_addr;
                write_q    <= req_write;
                poll_q     <= req_poll;
                half       <= 1'b0;
            end else if (state_nx == S_POPC && state != S_POPC) begin
                sh <= {STATUS_OP, {WIRE_W{1'b0}}};
            end else if (fall && (state == S_OPC || state == S_ADDR || state == S_POPC)) begin
                sh <= {sh[SH_W-5:0], 4'h0};
            end

            if (state == S_WFETCH && wr_valid) half <= !half;
            if (state == S_RPUSH && rd_ready)  half <= !half;

            if ((state == S_WSHIFT && last) || (state == S_RPUSH && rd_ready && half))
                pairs <= pairs - 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sclk     = sclk_q;
        busy     = (state != S_IDLE);
        cs_n     = (state == S_IDLE) || (state == S_END) || (state == S_PEND);
        wr_ready = (state == S_WFETCH);
        rd_valid = (state == S_RPUSH);
        rd_data  = half ? lane_byte[1] : lane_byte[0];
        done     = ((state == S_END) && !poll_q) || ((state == S_PEND) && !busy_any);
        err      = (state == S_IDLE) && req_valid && bad;
        q_oe     = 2'b00;
        q_out    = 8'h00;
        unique case (state)
            S_OPC, S_ADDR, S_POPC: begin
                q_oe  = 2'b11;
                q_out = {sh[SH_W-1 -: 4], sh[SH_W-1 -: 4]};
            end
            S_WSHIFT: begin
                q_oe  = 2'b11;
                q_out = {lane_nib[1], lane_nib[0]};
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    // R9: chip select leads the first rising clock edge by at least one cycle
    a_r9_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!cs_n && $past(!cs_n)));
    // R9: chip select is released only with the serial clock low
    a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk);
    // R8: bus data changes only while the serial clock is low
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> ($stable(q_out) && $stable(q_oe)));
    // R2: a stalled read byte is held
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R6 / R7: a refused request starts no frame
    a_r7_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> cs_n);
    // R12: an idle block holds the bus quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk && q_oe == 2'b00));

endmodule

// File: tb/test_dual_qflash_seq.sv
`timescale 1ns/1ps
module test_dual_qflash_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = 8'h00;
    logic [24:0] req_addr = '0;
    logic        req_has_addr = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_len = '0;
    logic [3:0]  req_dummy = '0;
    logic        req_poll = 1'b0;
    logic        busy, done, err;
    logic [7:0]  wr_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready;
    logic        sclk, cs_n;
    logic [7:0]  q_out;
    logic [1:0]  q_oe;
    logic [7:0]  q_in;

    always #2.5 clk = ~clk;

    dual_qflash_seq i_dual_qflash_seq (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .req_valid(req_valid), .req_opcode(req_opcode), .req_addr(req_addr),
        .req_has_addr(req_has_addr), .req_write(req_write), .req_len(req_len),
        .req_dummy(req_dummy), .req_poll(req_poll),
        .busy(busy), .done(done), .err(err),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .sclk(sclk), .cs_n(cs_n), .q_out(q_out), .q_oe(q_oe), .q_in(q_in)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device models and bus monitor ----------------
    logic [3:0] cap0 [0:127];
    logic [3:0] cap1 [0:127];
    int   rcnt = 0, frames = 0, stat_done = 0, stat_base = 0;
    int   lim0 = 0, lim1 = 0;
    int   m_start = 8;
    bit   m_rdframe = 1'b0;
    bit   fr_stat = 1'b0;
    int   oe_bad = 0, last_rises = 0;
    int   cyc = 0, cs_fall_cyc = 0, last_rise = 0, lead = 0, period = 0;
    bit   first_rise = 1'b0;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    logic [7:0] m_base = 8'h30;
    logic [7:0] exp_rd [$];
    int   rd_seen = 0;

    function automatic logic [7:0] mbyte(input int d, input int j);
        return 8'(int'(m_base) + 8'h40 * d + 3 * j);
    endfunction

    function automatic int wire_val(input int d, input int from, input int n);
        int v = 0;
        for (int i = 0; i < n; i++) v = (v << 4) | int'(d == 0 ? cap0[from+i] : cap1[from+i]);
        return v;
    endfunction

    always_comb begin
        logic [7:0] st;
        int k;
        q_in = 8'h00;
        if (fr_stat && rcnt >= 2 && rcnt < 4) begin
            for (int d = 0; d < 2; d++) begin
                st = ((stat_done - stat_base) < (d == 0 ? lim0 : lim1)) ? 8'hA1 : 8'hA0;
                q_in[d*4 +: 4] = (rcnt == 2) ? st[7:4] : st[3:0];
            end
        end else if (!fr_stat && rcnt >= m_start) begin
            k = rcnt - m_start;
            for (int d = 0; d < 2; d++) begin
                st = mbyte(d, k / 2);
                q_in[d*4 +: 4] = (k % 2 == 0) ? st[7:4] : st[3:0];
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (p_cs && !cs_n) begin
            rcnt = 0; frames++; cs_fall_cyc = cyc; first_rise = 1'b1; fr_stat = 1'b0;
        end
        if (!p_sclk && sclk) begin
            if (first_rise) begin lead = cyc - cs_fall_cyc; first_rise = 1'b0; end
            else period = cyc - last_rise;
            last_rise = cyc;
            if (rcnt < 128) begin
                if (q_oe[0]) cap0[rcnt] = q_out[3:0];
                if (q_oe[1]) cap1[rcnt] = q_out[7:4];
            end
            if (m_rdframe && rcnt >= 8 && q_oe != 2'b00) oe_bad++;
            rcnt++;
            if (rcnt == 2 && {cap0[0], cap0[1]} == 8'h05) fr_stat = 1'b1;
        end
        if (!p_cs && cs_n) begin
            last_rises = rcnt;
            if (fr_stat) stat_done++;
        end
        // scoreboard monitor for the read stream
        if (rd_valid && rd_ready) begin
            rd_seen++;
            if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R2 read byte order", rd_data, e);
            end
        end
        p_cs = cs_n; p_sclk = sclk;
    end

    // ---------------- stream drivers ----------------
    logic [7:0] wr_buf [0:63];
    int  wr_n = 0;
    bit  wr_start = 1'b0;

    initial begin
        int idx = 0;
        bit hs;
        wr_valid = 1'b0; wr_data = 8'h00;
        forever begin
            @(negedge clk);
            hs = wr_valid && wr_ready;
            @(posedge clk); #1;
            if (wr_start) begin idx = 0; wr_start = 1'b0; end
            else if (hs) idx++;
            wr_valid = (idx < wr_n);
            wr_data  = (idx < wr_n) ? wr_buf[idx] : 8'h00;
        end
    end

    initial begin
        int rr = 0;
        rd_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            rr++;
            rd_ready = (rr % 3) != 0;
        end
    end

    // ---------------- request driver ----------------
    bit got_done, got_err;

    task automatic run_req(input logic [7:0] op, input logic [24:0] a, input bit ha,
                           input bit wr, input int len, input int dm, input bit pl);
        int t = 0;
        got_done = 1'b0; got_err = 1'b0;
        @(posedge clk); #1;
        req_opcode = op; req_addr = a; req_has_addr = ha; req_write = wr;
        req_len = 12'(len); req_dummy = 4'(dm); req_poll = pl; req_valid = 1'b1;
        @(negedge clk);
        if (err) got_err = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!got_err) begin
            while (!done && t < 40000) begin @(negedge clk); t++; end
            got_done = done;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic expect_read(input int len);
        for (int i = 0; i < len; i++) exp_rd.push_back(mbyte(i % 2, i / 2));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        int f0;
        bit ok;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && q_oe == 2'b00, "R12 bus idle after reset",
            {cs_n, sclk, q_oe}, 4'b1000);
        chk(!busy && !done && !err && !wr_ready && !rd_valid, "R12 status idle after reset",
            {busy, done, err, wr_ready, rd_valid}, 0);

        // T1: read, dummy 4, logical 0x20000
        m_rdframe = 1'b1; m_start = 12; m_base = 8'h30; oe_bad = 0;
        expect_read(8);
        rd_seen = 0;
        run_req(8'h0B, 25'h20000, 1'b1, 1'b0, 8, 4, 1'b0);
        chk(got_done, "R2 read completes", got_done, 1);
        chk(rd_seen == 8 && exp_rd.size() == 0, "R2 read byte count", rd_seen, 8);
        chk(wire_val(0, 0, 2) == 8'h0B && wire_val(1, 0, 2) == 8'h0B, "R3 opcode on both buses",
            wire_val(1, 0, 2), 8'h0B);
        chk(wire_val(0, 2, 6) == 24'h010000 && wire_val(1, 2, 6) == 24'h010000,
            "R3 halved address", wire_val(0, 2, 6), 24'h010000);
        chk(oe_bad == 0, "R10 no drive during dummy and read", oe_bad, 0);
        chk(period == 4, "R8 sclk period at cfg_div=1", period, 4);
        chk(lead >= 1, "R9 cs lead", lead, 1);

        // T2: page program at 0x400
        m_rdframe = 1'b0; m_start = 8;
        for (int i = 0; i < 8; i++) wr_buf[i] = 8'(8'h1A + 8'h11 * i);
        wr_n = 8; wr_start = 1'b1;
        run_req(8'h02, 25'h400, 1'b1, 1'b1, 8, 0, 1'b0);
        chk(got_done, "R1 program completes", got_done, 1);
        chk(wire_val(0, 2, 6) == 24'h000200, "R3 program address halved", wire_val(0, 2, 6), 24'h200);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (wire_val(i % 2, 8 + 2 * (i / 2), 2) != int'(wr_buf[i])) ok = 1'b0;
        end
        chk(ok, "R1 even/odd byte split high nibble first", wire_val(1, 8, 2), wr_buf[1]);
        wr_n = 0;

        // T3: unaligned program
        f0 = frames;
        run_req(8'h02, 25'h500, 1'b1, 1'b1, 8, 0, 1'b0);
        chk(got_err, "R6 unaligned program refused", got_err, 1);
        chk(frames == f0, "R6 no frame on refusal", frames, f0);

        // T4: odd length
        f0 = frames;
        run_req(8'h0B, 25'h0, 1'b1, 1'b0, 7, 4, 1'b0);
        chk(got_err, "R7 odd count refused", got_err, 1);
        chk(frames == f0, "R7 no frame on refusal", frames, f0);

        // T5: erase with device 1 slower
        lim0 = 2; lim1 = 4; stat_base = stat_done;
        run_req(8'hD8, 25'h20000, 1'b1, 1'b0, 0, 0, 1'b1);
        chk(got_done, "R5 erase poll completes", got_done, 1);
        chk(stat_done - stat_base == 5, "R4 poll frames until both ready (dev1 slow)",
            stat_done - stat_base, 5);

        // T6: erase with device 0 slower
        lim0 = 3; lim1 = 1; stat_base = stat_done;
        run_req(8'hD8, 25'h40000, 1'b1, 1'b0, 0, 0, 1'b1);
        chk(got_done, "R5 erase poll completes", got_done, 1);
        chk(stat_done - stat_base == 4, "R5 waits for slower device 0",
            stat_done - stat_base, 4);
        chk(wire_val(0, 0, 2) == 8'h05, "R4 poll frame opcode", wire_val(0, 0, 2), 8'h05);

        // T7: opcode only
        run_req(8'h06, 25'h0, 1'b0, 1'b0, 0, 0, 1'b0);
        chk(got_done, "R11 bare opcode completes", got_done, 1);
        chk(last_rises == 2, "R11 frame of two clocks", last_rises, 2);

        // T8: read at a wider divider, no dummy
        cfg_div = 8'd2;
        m_rdframe = 1'b1; m_start = 8; m_base = 8'h55; oe_bad = 0; rd_seen = 0;
        expect_read(4);
        run_req(8'h6B, 25'h1234, 1'b1, 1'b0, 4, 0, 1'b0);
        chk(got_done && rd_seen == 4, "R2 read without dummy", rd_seen, 4);
        chk(period == 6, "R8 sclk period at cfg_div=2", period, 6);
        chk(lead >= 1, "R9 cs lead at cfg_div=2", lead, 1);
        chk(oe_bad == 0, "R10 no drive during read", oe_bad, 0);
        chk(wire_val(1, 2, 6) == 24'h00091A, "R3 halved address odd start", wire_val(1, 2, 6), 24'h91A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule